// File: doc/BRIEF.md
# Frame Buffer Access Cycle Sequencer

This block owns the shared frame-buffer bus and decides, memory cycle by memory cycle, which of four clients may use it: the screen refresh address generator (background screen), the window screen generator, the drawing engine, and DRAM refresh. Every memory cycle is built from phases of the fast clock. An address phase puts an address on the multiplexed address/data bus and raises the address strobe. A data phase sets the read direction, and carries write data when the drawing engine writes.

Three access modes are selected by an input. Single mode uses a two-phase cycle for one client. Interleaved mode uses a four-phase cycle that gives the first half to the display and the second half to drawing. Superimposed mode gives the second half to the window screen and hands it to drawing when the window does not need it. In single mode a priority input chooses between display priority, where drawing runs only in blanking, and drawing priority. While horizontal sync is low, and from reset until the start input is set, every access is a refresh access that drives an 8-bit down counter on the bus.

The drawing engine holds its request until it sees done. A grant pulse marks its address phase and a done pulse marks its data phase.

Top module: `fbuf_cycle_seq`

## Requirements
- R1: In single mode (mode_i = 0) an access takes two clocks: an address phase with mem_as_o high, then a data phase with mem_as_o low. mem_cyc_o is high in every address phase and low in every data phase, so it toggles on each clock. mem_as_o is never high on two consecutive clocks.
- R2: In single mode with display priority (draw_pri_i = 0), a held drawing request gets an access only if hblank_i or vblank_i is high at the clock edge that starts the address phase. Otherwise a display request is served, or the slot stays idle.
- R3: In single mode with drawing priority (draw_pri_i = 1), a drawing request takes the access ahead of a display request.
- R4: In interleaved mode (mode_i = 1, and also mode_i = 3) an access takes four clocks: display address, display data, drawing address, drawing data. An unused half stays idle.
- R5: In superimposed mode (mode_i = 2) the first half serves the background display request. The second half serves the window request when win_req_i is high, and otherwise a held drawing request.
- R6: When hsync_n_i is low at the edge that starts an address phase, that access is a refresh access. mem_ad_o carries the refresh count in bits 7:0 and zeros above, mem_draw_o stays low and no grant is given.
- R7: The refresh count is 0 after reset and decrements by one, wrapping from 0x00 to 0xFF, after every access of any kind.
- R8: While start_i is low, every access is a refresh access and hsync_n_o is held low. Once start_i is high, hsync_n_o follows hsync_n_i.
- R9: mem_draw_o is high through both phases of a drawing access. mem_rd_o is high in the data phase of display, window and drawing-read accesses, and low otherwise. In a drawing-write data phase, mem_ad_o carries drw_wdata_i zero-extended.
- R10: A drawing request that is not granted stays pending until a permitted slot comes up. It is then granted with drw_gnt_o in the address phase and drw_done_o in the next clock.
- R11: During reset mem_as_o, mem_draw_o, mem_rd_o, mem_cyc_o, drw_gnt_o and drw_done_o are low, and mem_ad_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (two phases per single-mode access) |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start bit; low keeps refresh-only operation |
| mode_i | input | 2 | 0 single, 1 or 3 interleaved, 2 superimposed |
| draw_pri_i | input | 1 | Single mode: 1 drawing priority, 0 display priority |
| hblank_i | input | 1 | Horizontal blanking |
| vblank_i | input | 1 | Vertical blanking |
| hsync_n_i | input | 1 | Horizontal sync from timing generator, active low |
| disp_req_i | input | 1 | Background display fetch request |
| disp_addr_i | input | ADDR_W | Background display address |
| win_req_i | input | 1 | Window display fetch request |
| win_addr_i | input | ADDR_W | Window display address |
| drw_req_i | input | 1 | Drawing request, held until done |
| drw_we_i | input | 1 | Drawing access is a write |
| drw_addr_i | input | ADDR_W | Drawing address |
| drw_wdata_i | input | DATA_W | Drawing write data |
| drw_gnt_o | output | 1 | Drawing address phase in progress |
| drw_done_o | output | 1 | Drawing data phase in progress |
| mem_ad_o | output | ADDR_W | Multiplexed address/data bus |
| mem_as_o | output | 1 | Address strobe |
| mem_draw_o | output | 1 | Drawing access indicator |
| mem_rd_o | output | 1 | Read direction in data phase |
| mem_cyc_o | output | 1 | Memory cycle timing, half the clock rate |
| hsync_n_o | output | 1 | Horizontal sync to display, held low before start |

## Verification
The bench uses the default parameters: a 20-bit bus, 16-bit write data, an 8-bit refresh counter and the superimposed variant built in. With SUPER_EN set, mode 2 reaches the window slot, and a disabled window shows drawing taking over the second half. With an 8-bit counter that resets to zero, the wrap to 0xFF shows up on the second refresh access. A mixed run of refresh and display accesses shows that every access type moves the counter.

// File: rtl/fbseq_pkg.sv
`timescale 1ns/1ps
package fbseq_pkg;

   typedef enum logic [2:0] {
      OWN_IDLE = 3'd0,
      OWN_DISP = 3'd1,
      OWN_WIN  = 3'd2,
      OWN_DRAW = 3'd3,
      OWN_RFSH = 3'd4
   } owner_e;

   localparam logic [1:0] MODE_SINGLE = 2'd0;
   localparam logic [1:0] MODE_INTLV  = 2'd1;
   localparam logic [1:0] MODE_SUPER  = 2'd2;

endpackage

// File: rtl/fbseq_phase.sv
`timescale 1ns/1ps
module fbseq_phase (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   output logic       addr_ph_o,
   output logic       nxt_addr_o,
   output logic       nxt_hi_o
);
   import fbseq_pkg::*;

   logic [1:0] ph_q;
   logic [1:0] ph_d;

   always_comb begin
      if (mode_i == MODE_SINGLE) ph_d = {1'b0, ~ph_q[0]};
      else                       ph_d = ph_q + 2'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 2'd3;
      else        ph_q <= ph_d;
   end

   assign addr_ph_o  = ~ph_q[0];
   assign nxt_addr_o = ~ph_d[0];
   assign nxt_hi_o   = ph_d[1];

   AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!ph_q[0]) |=> ph_q[0]); // R1
endmodule

// File: rtl/fbseq_arbiter.sv
`timescale 1ns/1ps
module fbseq_arbiter #(
   parameter bit SUPER_EN = 1'b1
) (
   input  logic              [1:0] mode_i,
   input  logic                    second_half_i,
   input  logic                    rfsh_force_i,
   input  logic                    draw_pri_i,
   input  logic                    hblank_i,
   input  logic                    vblank_i,
   input  logic                    disp_req_i,
   input  logic                    win_req_i,
   input  logic                    drw_req_i,
   output fbseq_pkg::owner_e       own_o
);
   import fbseq_pkg::*;

   logic win_ok;
   logic single;

   generate
      if (SUPER_EN) begin : g_super
         assign win_ok = (mode_i == MODE_SUPER);
      end else begin : g_nosuper
         assign win_ok = 1'b0;
      end
   endgenerate

   assign single = (mode_i == MODE_SINGLE);

   always_comb begin
      own_o = OWN_IDLE;
      if (rfsh_force_i) begin
         own_o = OWN_RFSH;
      end else if (single) begin
         if (drw_req_i && (draw_pri_i || hblank_i || vblank_i)) own_o = OWN_DRAW;
         else if (disp_req_i)                                   own_o = OWN_DISP;
      end else if (!second_half_i) begin
         if (disp_req_i) own_o = OWN_DISP;
      end else if (win_ok && win_req_i) begin
         own_o = OWN_WIN;
      end else if (drw_req_i) begin
         own_o = OWN_DRAW;
      end
   end
endmodule

// File: rtl/fbseq_rfsh_cnt.sv
`timescale 1ns/1ps
module fbseq_rfsh_cnt #(
   parameter int RCNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   output logic [RCNT_W-1:0] cnt_o
);
   localparam logic [RCNT_W-1:0] ONE = {{(RCNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (step_i) cnt_o <= cnt_o - ONE;
   end

   AST_RFSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (cnt_o == $past(cnt_o) - ONE)); // R7
   AST_RFSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/fbuf_cycle_seq.sv
`timescale 1ns/1ps
module fbuf_cycle_seq #(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter int RCNT_W   = 8,
   parameter bit SUPER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic              draw_pri_i,
   input  logic              hblank_i,
   input  logic              vblank_i,
   input  logic              hsync_n_i,
   input  logic              disp_req_i,
   input  logic [ADDR_W-1:0] disp_addr_i,
   input  logic              win_req_i,
   input  logic [ADDR_W-1:0] win_addr_i,
   input  logic              drw_req_i,
   input  logic              drw_we_i,
   input  logic [ADDR_W-1:0] drw_addr_i,
   input  logic [DATA_W-1:0] drw_wdata_i,
   output logic              drw_gnt_o,
   output logic              drw_done_o,
   output logic [ADDR_W-1:0] mem_ad_o,
   output logic              mem_as_o,
   output logic              mem_draw_o,
   output logic              mem_rd_o,
   output logic              mem_cyc_o,
   output logic              hsync_n_o
);
   import fbseq_pkg::*;

   localparam int RPAD_W = ADDR_W - RCNT_W;
   localparam int DPAD_W = ADDR_W - DATA_W;

   initial begin
      assert (RCNT_W >= 1 && RCNT_W <= ADDR_W) else $fatal(1, "refresh counter wider than bus");
      assert (DATA_W >= 1 && DATA_W <= ADDR_W) else $fatal(1, "write data wider than bus");
   end

   logic              addr_ph;
   logic              nxt_addr;
   logic              nxt_hi;
   logic              rfsh_force;
   owner_e            own_nxt;
   owner_e            own_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_d;
   logic [ADDR_W-1:0] wdata_q;
   logic [ADDR_W-1:0] wdata_ext;
   logic [ADDR_W-1:0] rfsh_ext;
   logic [RCNT_W-1:0] rcnt;
   logic              step;

   fbseq_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .addr_ph_o  (addr_ph),
      .nxt_addr_o (nxt_addr),
      .nxt_hi_o   (nxt_hi)
   );

   assign rfsh_force = !start_i || !hsync_n_i;

   fbseq_arbiter #(.SUPER_EN(SUPER_EN)) u_arb (
      .mode_i        (mode_i),
      .second_half_i (nxt_hi),
      .rfsh_force_i  (rfsh_force),
      .draw_pri_i    (draw_pri_i),
      .hblank_i      (hblank_i),
      .vblank_i      (vblank_i),
      .disp_req_i    (disp_req_i),
      .win_req_i     (win_req_i),
      .drw_req_i     (drw_req_i),
      .own_o         (own_nxt)
   );

   assign step = nxt_addr && (own_nxt != OWN_IDLE);

   fbseq_rfsh_cnt #(.RCNT_W(RCNT_W)) u_rcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .cnt_o  (rcnt)
   );

   generate
      if (RPAD_W > 0) begin : g_rpad
         assign rfsh_ext = {{RPAD_W{1'b0}}, rcnt};
      end else begin : g_rnopad
         assign rfsh_ext = rcnt;
      end
      if (DPAD_W > 0) begin : g_dpad
         assign wdata_ext = {{DPAD_W{1'b0}}, drw_wdata_i};
      end else begin : g_dnopad
         assign wdata_ext = drw_wdata_i;
      end
   endgenerate

   always_comb begin
      case (own_nxt)
         OWN_DISP: addr_d = disp_addr_i;
         OWN_WIN:  addr_d = win_addr_i;
         OWN_DRAW: addr_d = drw_addr_i;
         OWN_RFSH: addr_d = rfsh_ext;
         default:  addr_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q   <= OWN_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
      end else if (nxt_addr) begin
         own_q   <= own_nxt;
         addr_q  <= addr_d;
         wdata_q <= wdata_ext;
         we_q    <= drw_we_i;
      end
   end

   logic busy;
   logic drw_wr;
   assign busy   = (own_q != OWN_IDLE);
   assign drw_wr = (own_q == OWN_DRAW) && we_q;

   assign mem_cyc_o  = addr_ph;
   assign mem_as_o   = addr_ph && busy;
   assign mem_draw_o = (own_q == OWN_DRAW);
   assign mem_rd_o   = !addr_ph && busy && (own_q != OWN_RFSH) && !drw_wr;
   assign drw_gnt_o  = addr_ph && (own_q == OWN_DRAW);
   assign drw_done_o = !addr_ph && (own_q == OWN_DRAW);
   assign hsync_n_o  = start_i && hsync_n_i;

   always_comb begin
      if (addr_ph && busy)      mem_ad_o = addr_q;
      else if (!addr_ph && drw_wr) mem_ad_o = wdata_q;
      else                      mem_ad_o = '0;
   end

   AST_ONE_CLK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_as_o |=> !mem_as_o); // R1
   AST_DISP_PRI_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_as_o && mem_draw_o && $past(mode_i) == MODE_SINGLE)
         |-> $past(draw_pri_i || hblank_i || vblank_i)); // R2
   AST_RFSH_NO_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_as_o && (!$past(start_i) || !$past(hsync_n_i))) |-> (!mem_draw_o && !drw_gnt_o)); // R6
   AST_GNT_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      drw_gnt_o |=> drw_done_o); // R10
   AST_WRITE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (drw_done_o && $past(drw_we_i)) |-> !mem_rd_o); // R9
endmodule

// File: tb/sim_fbuf_cycle_seq.sv
`timescale 1ns/1ps
module sim_fbuf_cycle_seq;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam logic [AW-1:0] DISP_A = 20'h11111;
   localparam logic [AW-1:0] WIN_A  = 20'h22222;
   localparam logic [AW-1:0] DRW_A  = 20'h33333;
   // owner codes seen at the ports: 0 idle, 1 display, 2 window, 3 draw, 4 refresh
   // vector: mode[14:13] pri hbl vbl hs_n disp win drw  slotA[5:3] slotB[2:0]
   localparam int NV = 14;
   localparam logic [14:0] VEC [NV] = '{
      15'b00_0_0_0_1_1_0_1_001_001, // R2 active display wins
      15'b00_0_1_0_1_1_0_1_011_011, // R2 hblank lets drawing in
      15'b00_0_0_1_1_1_0_1_011_011, // R2 vblank lets drawing in
      15'b00_1_0_0_1_1_0_1_011_011, // R3 drawing priority
      15'b00_1_0_0_1_1_0_0_001_001, // R3 no draw request
      15'b00_0_0_0_1_0_0_1_000_000, // R10 pending, idle
      15'b01_0_0_0_1_1_0_1_001_011, // R4
      15'b01_0_0_0_1_0_0_1_000_011, // R4
      15'b01_0_0_0_1_1_0_0_001_000, // R4
      15'b10_0_0_0_1_1_1_1_001_010, // R5 window first
      15'b10_0_0_0_1_1_0_1_001_011, // R5 drawing fills
      15'b10_0_0_0_1_0_1_0_000_010, // R5
      15'b00_1_0_0_0_1_0_1_100_100, // R6 single
      15'b01_0_0_0_0_1_1_1_100_100  // R6 interleaved
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic draw_pri_i = 1'b0, hblank_i = 1'b0, vblank_i = 1'b0, hsync_n_i = 1'b1;
   logic disp_req_i = 1'b0, win_req_i = 1'b0, drw_req_i = 1'b0, drw_we_i = 1'b0;
   logic [DW-1:0] drw_wdata_i = '0;
   logic drw_gnt_o, drw_done_o, mem_as_o, mem_draw_o, mem_rd_o, mem_cyc_o, hsync_n_o;
   logic [AW-1:0] mem_ad_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fbuf_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .draw_pri_i(draw_pri_i), .hblank_i(hblank_i), .vblank_i(vblank_i),
      .hsync_n_i(hsync_n_i), .disp_req_i(disp_req_i), .disp_addr_i(DISP_A),
      .win_req_i(win_req_i), .win_addr_i(WIN_A), .drw_req_i(drw_req_i),
      .drw_we_i(drw_we_i), .drw_addr_i(DRW_A), .drw_wdata_i(drw_wdata_i),
      .drw_gnt_o(drw_gnt_o), .drw_done_o(drw_done_o), .mem_ad_o(mem_ad_o),
      .mem_as_o(mem_as_o), .mem_draw_o(mem_draw_o), .mem_rd_o(mem_rd_o),
      .mem_cyc_o(mem_cyc_o), .hsync_n_o(hsync_n_o)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic int owner();
      if (!mem_as_o)                return 0;
      if (mem_draw_o)               return 3;
      if (mem_ad_o == DISP_A)       return 1;
      if (mem_ad_o == WIN_A)        return 2;
      if (mem_ad_o[AW-1:8] == '0)   return 4;
      return 7;
   endfunction

   task automatic restart();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R11 reset state, R8 hsync held low before start
      rst_n = 1'b0;
      tick();
      chk("R11 as", mem_as_o, 0);
      chk("R11 draw", mem_draw_o, 0);
      chk("R11 rd", mem_rd_o, 0);
      chk("R11 cyc", mem_cyc_o, 0);
      chk("R11 gnt/done", {drw_gnt_o, drw_done_o}, 0);
      chk("R11 bus", mem_ad_o, 0);
      chk("R8 hsync low before start", hsync_n_o, 0);

      // table walk: two address phases per vector
      for (int i = 0; i < NV; i++) begin
         start_i = 1'b1;
         mode_i = VEC[i][14:13];
         draw_pri_i = VEC[i][12];
         hblank_i = VEC[i][11];
         vblank_i = VEC[i][10];
         hsync_n_i = VEC[i][9];
         disp_req_i = VEC[i][8];
         win_req_i = VEC[i][7];
         drw_req_i = VEC[i][6];
         drw_we_i = 1'b0;
         restart();
         tick();
         chk($sformatf("R2-5 vec%0d slot A", i), owner(), int'(VEC[i][5:3]));
         tick();
         tick();
         chk($sformatf("R2-5 vec%0d slot B", i), owner(), int'(VEC[i][2:0]));
      end

      // R1 single-mode phase timing
      mode_i = 2'd0; draw_pri_i = 1'b0; hblank_i = 1'b0; vblank_i = 1'b0;
      hsync_n_i = 1'b1; disp_req_i = 1'b1; win_req_i = 1'b0; drw_req_i = 1'b0;
      restart();
      tick();
      chk("R1 addr phase strobe", mem_as_o, 1);
      chk("R1 addr phase cyc", mem_cyc_o, 1);
      chk("R1 addr on bus", mem_ad_o, DISP_A);
      chk("R9 no read in addr phase", mem_rd_o, 0);
      tick();
      chk("R1 data phase strobe", mem_as_o, 0);
      chk("R1 data phase cyc", mem_cyc_o, 0);
      chk("R9 display read", mem_rd_o, 1);
      tick();
      chk("R1 next access strobe", mem_as_o, 1);

      // R9 drawing write and read
      disp_req_i = 1'b0; draw_pri_i = 1'b1; drw_req_i = 1'b1; drw_we_i = 1'b1;
      drw_wdata_i = 16'hABCD;
      restart();
      tick();
      chk("R10 grant", drw_gnt_o, 1);
      chk("R9 draw flag addr", mem_draw_o, 1);
      chk("R9 draw addr", mem_ad_o, DRW_A);
      tick();
      chk("R10 done", drw_done_o, 1);
      chk("R9 draw flag data", mem_draw_o, 1);
      chk("R9 write no read", mem_rd_o, 0);
      chk("R9 write data", mem_ad_o, 20'h0ABCD);
      drw_we_i = 1'b0;
      restart();
      tick();
      tick();
      chk("R9 draw read dir", mem_rd_o, 1);
      chk("R9 read bus idle", mem_ad_o, 0);

      // R4 interleaved four phases, R1 cyc toggles
      mode_i = 2'd1; draw_pri_i = 1'b0; disp_req_i = 1'b1;
      restart();
      tick();
      chk("R4 p0 display", owner(), 1);
      chk("R1 p0 cyc", mem_cyc_o, 1);
      tick();
      chk("R1 p1 cyc", mem_cyc_o, 0);
      chk("R4 p1 read no draw", {mem_rd_o, mem_draw_o}, 2'b10);
      tick();
      chk("R4 p2 draw", owner(), 3);
      chk("R1 p2 cyc", mem_cyc_o, 1);
      tick();
      chk("R4 p3 draw done", {drw_done_o, mem_rd_o}, 2'b11);

      // R10 pending drawing request waits for blanking
      mode_i = 2'd0; draw_pri_i = 1'b0; hblank_i = 1'b0;
      restart();
      tick();
      chk("R10 not granted", {owner(), drw_gnt_o}, 2);
      hblank_i = 1'b1;
      tick();
      chk("R10 no done", drw_done_o, 0);
      tick();
      chk("R10 granted at blank", {owner(), drw_gnt_o}, 7);
      tick();
      chk("R10 done after grant", drw_done_o, 1);
      drw_req_i = 1'b0;
      tick();
      chk("R10 display after done", owner(), 1);
      hblank_i = 1'b0;

      // R7 refresh count with wrap and shared decrement
      hsync_n_i = 1'b0; disp_req_i = 1'b1; drw_req_i = 1'b0;
      restart();
      tick();
      chk("R7 first refresh", owner() * 256 + int'(mem_ad_o), 4 * 256 + 0);
      tick();
      tick();
      chk("R7 wrap refresh", owner() * 256 + int'(mem_ad_o), 4 * 256 + 255);
      hsync_n_i = 1'b1;
      tick();
      tick();
      chk("R7 display access", owner(), 1);
      hsync_n_i = 1'b0;
      tick();
      tick();
      chk("R7 count after display", owner() * 256 + int'(mem_ad_o), 4 * 256 + 253);
      chk("R6 upper bits zero", int'(mem_ad_o[AW-1:8]), 0);

      // R8 refresh only before start
      start_i = 1'b0; hsync_n_i = 1'b1;
      restart();
      tick();
      chk("R8 refresh before start", owner(), 4);
      chk("R8 hsync held", hsync_n_o, 0);
      start_i = 1'b1;
      #1;
      chk("R8 hsync follows", hsync_n_o, 1);
      tick();
      tick();
      chk("R8 display after start", owner(), 1);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule